// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block resolves branch-class instructions for a 16-bit processor. Each cycle it takes an instruction word, the program counter (already stepped past the instruction), the four condition flags and the value of one general register. It classifies the word as a short conditional branch, a count-down loop instruction, or something else. From that it produces a registered decision one cycle later: whether control transfers, the address to continue at, and for the loop instruction a register write-back.

Short branches carry a signed word displacement in the low byte. Their condition is selected by bit 15 together with bits 10..8. With bit 15 clear, the conditions cover equality and signed ordering, built from Z and N XOR V. With bit 15 set, they cover single flags and unsigned ordering, built from C and Z. The loop instruction decrements a register, writes it back in every case, and jumps backward by an unsigned word count when the new value is nonzero.

Top module: `bcu_top`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it rises with no recognised instruction, every output is zero.
- R2: Outputs are registered and show the result for the inputs sampled at the previous rising edge of `clk`. For a taken short branch, `target_o` = `pc_i` + 2 × (instr[7:0] read as two's complement), modulo 2^16.
- R3: A short branch has instr[14:11] = 0000. With instr[15] = 0, instr[10:8] selects the condition: 1 always; 2 Z=0; 3 Z=1; 4 (N^V)=0; 5 (N^V)=1; 6 (Z|(N^V))=0; 7 (Z|(N^V))=1. `flags_i` is {N,Z,V,C}, with N in bit 3.
- R4: With instr[15] = 1 and instr[14:11] = 0000, instr[10:8] selects the condition: 0 N=0; 1 N=1; 2 (C|Z)=0; 3 (C|Z)=1; 4 V=0; 5 V=1; 6 C=0; 7 C=1.
- R5: For any recognised instruction that does not transfer control, `taken_o` = 0 and `target_o` equals the sampled `pc_i`.
- R6: The loop instruction has instr[15:9] = 0111111. It always gives `wr_en_o` = 1, `wr_sel_o` = instr[8:6] and `wr_data_o` = `reg_i` − 1, wrapping 0 to FFFF.
- R7: The loop instruction is taken exactly when `reg_i` − 1 is nonzero. Its target is then `pc_i` − 2 × instr[5:0], with instr[5:0] read as unsigned.
- R8: Any other encoding, including instr[15:8] = 00000000, gives `valid_o` = 0, `taken_o` = 0, `wr_en_o` = 0, `wr_sel_o` = 0, `wr_data_o` = 0 and `target_o` = `pc_i`.
- R9: A short branch gives `valid_o` = 1 and never writes a register: `wr_en_o`, `wr_sel_o` and `wr_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter past the instruction |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| reg_i | input | 16 | Value of the register named by a loop instruction |
| valid_o | output | 1 | Recognised branch or loop instruction |
| taken_o | output | 1 | Control transfers |
| target_o | output | 16 | Next address |
| wr_en_o | output | 1 | Register write-back enable |
| wr_sel_o | output | 3 | Register number to write |
| wr_data_o | output | 16 | Decremented register value |

## Verification
The bench sweeps all sixteen condition selectors against all sixteen flag patterns. A selector swapped with its complement, or a signed test built from N alone, shows up as a wrong `taken_o` on specific flag rows. Displacements of 0x7F, 0x80 and 0xFF are tried, because a design that zero-extends the byte would send backward branches far forward. For the loop instruction, register values of 1, 0 and 2 check the case where the count reaches zero and the case where it wraps. A design that tests the old value instead of the new one would branch on 1 and fall through on 0. The bench also drives the reserved row with bit 15 clear and selector 0, and encodings just outside both groups, since a loose decoder would report them as valid.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_BR   = 2'd1,
    CLS_LOOP = 2'd2
  } bcu_cls_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } bcu_flags_t;

  // condition selector is {instr[15], instr[10:8]}
  function automatic logic bcu_cond_eval(input logic [3:0] sel, input bcu_flags_t f);
    logic sx;
    logic res;
    sx = f.n ^ f.v;
    case (sel)
      4'h1:    res = 1'b1;
      4'h2:    res = ~f.z;
      4'h3:    res = f.z;
      4'h4:    res = ~sx;
      4'h5:    res = sx;
      4'h6:    res = ~(f.z | sx);
      4'h7:    res = f.z | sx;
      4'h8:    res = ~f.n;
      4'h9:    res = f.n;
      4'hA:    res = ~(f.c | f.z);
      4'hB:    res = f.c | f.z;
      4'hC:    res = ~f.v;
      4'hD:    res = f.v;
      4'hE:    res = ~f.c;
      4'hF:    res = f.c;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic [IW-1:0] instr,
  output bcu_cls_e      cls,
  output logic [3:0]    cond_sel,
  output logic [2:0]    reg_sel,
  output logic [7:0]    disp8,
  output logic [5:0]    disp6
);
  localparam logic [6:0] LOOP_OP = 7'b0111111;

  logic grp_zero;
  logic reserved_row;

  assign grp_zero     = (instr[14:11] == 4'b0000);
  assign reserved_row = ~instr[15] & (instr[10:8] == 3'b000);
  assign cond_sel     = {instr[15], instr[10:8]};
  assign reg_sel      = instr[8:6];
  assign disp8        = instr[7:0];
  assign disp6        = instr[5:0];

  always_comb begin
    if (instr[15:9] == LOOP_OP)           cls = CLS_LOOP;
    else if (grp_zero && !reserved_row)   cls = CLS_BR;
    else                                  cls = CLS_NONE;
  end
endmodule

// File: rtl/bcu_target.sv
module bcu_target
  import bcu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  bcu_cls_e      cls,
  input  logic          take,
  input  logic [7:0]    disp8,
  input  logic [5:0]    disp6,
  output logic [AW-1:0] target
);
  localparam int SX_PAD = AW - 9;
  localparam int ZX_PAD = AW - 7;

  function automatic logic [AW-1:0] fwd_bytes(input logic [7:0] d);
    return {{SX_PAD{d[7]}}, d, 1'b0};
  endfunction

  function automatic logic [AW-1:0] back_bytes(input logic [5:0] d);
    return {{ZX_PAD{1'b0}}, d, 1'b0};
  endfunction

  always_comb begin
    target = pc;
    if (take) begin
      if (cls == CLS_BR)        target = pc + fwd_bytes(disp8);
      else if (cls == CLS_LOOP) target = pc - back_bytes(disp6);
    end
  end
endmodule

// File: rtl/bcu_top.sv
module bcu_top
  import bcu_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [3:0]    flags_i,
  input  logic [RW-1:0] reg_i,
  output logic          valid_o,
  output logic          taken_o,
  output logic [AW-1:0] target_o,
  output logic          wr_en_o,
  output logic [2:0]    wr_sel_o,
  output logic [RW-1:0] wr_data_o
);
  localparam logic [RW-1:0] ONE = RW'(1);

  bcu_cls_e      cls;
  logic [3:0]    cond_sel;
  logic [2:0]    reg_sel;
  logic [7:0]    disp8;
  logic [5:0]    disp6;
  logic          cond_hit;
  logic [RW-1:0] loop_dec;
  logic          loop_nz;
  logic          take_now;
  logic [AW-1:0] tgt_now;
  bcu_flags_t    fl;

  assign fl = bcu_flags_t'(flags_i);

  bcu_decode #(.IW(16)) u_dec (
    .instr(instr_i), .cls(cls), .cond_sel(cond_sel),
    .reg_sel(reg_sel), .disp8(disp8), .disp6(disp6)
  );

  assign cond_hit = bcu_cond_eval(cond_sel, fl);
  assign loop_dec = reg_i - ONE;
  assign loop_nz  = |loop_dec;

  always_comb begin
    case (cls)
      CLS_BR:   take_now = cond_hit;
      CLS_LOOP: take_now = loop_nz;
      default:  take_now = 1'b0;
    endcase
  end

  bcu_target #(.AW(AW)) u_tgt (
    .pc(pc_i), .cls(cls), .take(take_now),
    .disp8(disp8), .disp6(disp6), .target(tgt_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      target_o  <= '0;
      wr_en_o   <= 1'b0;
      wr_sel_o  <= '0;
      wr_data_o <= '0;
    end else begin
      valid_o   <= (cls != CLS_NONE);
      taken_o   <= take_now;
      target_o  <= tgt_now;
      wr_en_o   <= (cls == CLS_LOOP);
      wr_sel_o  <= (cls == CLS_LOOP) ? reg_sel : 3'd0;
      wr_data_o <= (cls == CLS_LOOP) ? loop_dec : '0;
    end
  end

  // R8
  inv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!taken_o && !wr_en_o));

  // R5
  fallthru_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls != CLS_NONE && !take_now) |=> (target_o == $past(pc_i)));

  // R6
  wb_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_LOOP) |=> (wr_en_o && wr_data_o == $past(reg_i) - ONE));

  // R7
  loop_take_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && taken_o) |-> (wr_data_o != '0));

  // R9
  br_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_BR) |=> (valid_o && !wr_en_o));
endmodule

// File: tb/bcu_top_bench.sv
module bcu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_i = '0;
  logic [3:0]  flags_i = '0;
  logic [15:0] reg_i = '0;
  logic        valid_o, taken_o, wr_en_o;
  logic [15:0] target_o, wr_data_o;
  logic [2:0]  wr_sel_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bcu_top u_bcu_top (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .pc_i(pc_i),
    .flags_i(flags_i), .reg_i(reg_i), .valid_o(valid_o), .taken_o(taken_o),
    .target_o(target_o), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
    .wr_data_o(wr_data_o)
  );

  // reference: {valid, taken, target, wr_en, wr_sel, wr_data}
  function automatic logic [37:0] model(input logic [15:0] i, input logic [15:0] pc,
                                        input logic [3:0] f, input logic [15:0] r);
    bit n, z, v, c, tk, ok;
    int sel, off, t;
    logic [15:0] d;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    if (i[15:9] == 7'o77) begin
      d  = r - 16'd1;
      tk = (d != 0);
      t  = tk ? (int'(pc) - 2 * int'(i[5:0])) : int'(pc);
      return {1'b1, tk, 16'(t), 1'b1, i[8:6], d};
    end
    ok = (i[14:11] == 0) && !(i[15] == 0 && i[10:8] == 0);
    if (!ok) return {2'b00, pc, 1'b0, 3'd0, 16'd0};
    sel = (i[15] ? 8 : 0) + int'(i[10:8]);
    case (sel)
      1: tk = 1;           2: tk = !z;          3: tk = z;
      4: tk = (n == v);    5: tk = (n != v);
      6: tk = !z && (n == v);  7: tk = z || (n != v);
      8: tk = !n;          9: tk = n;
      10: tk = !c && !z;   11: tk = c || z;
      12: tk = !v;         13: tk = v;
      14: tk = !c;         default: tk = c;
    endcase
    off = int'($signed(i[7:0]));
    t = tk ? int'(pc) + 2 * off : int'(pc);
    return {1'b1, tk, 16'(t), 1'b0, 3'd0, 16'd0};
  endfunction

  task automatic check(input string tag, input logic [37:0] exp);
    logic [37:0] act;
    act = {valid_o, taken_o, target_o, wr_en_o, wr_sel_o, wr_data_o};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] i, input logic [15:0] pc,
                      input logic [3:0] f, input logic [15:0] r);
    logic [37:0] exp;
    @(negedge clk);
    instr_i = i; pc_i = pc; flags_i = f; reg_i = r;
    exp = model(i, pc, f, r);
    @(posedge clk);
    #1;
    check(tag, exp);
  endtask

  initial begin
    #20000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", 38'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {2'b00, 16'd0, 1'b0, 3'd0, 16'd0});

    // R3 R4 R5: every selector against every flag pattern
    for (int s = 0; s < 16; s++)
      for (int fl = 0; fl < 16; fl++)
        step(s < 8 ? "R3" : "R4",
             {s[3], 4'b0000, s[2:0], 8'h05}, 16'h1000 + 16'(fl * 4), 4'(fl), 16'h0);

    // R2: displacement extremes on an always-taken branch
    step("R2", 16'h017F, 16'h2000, 4'h0, 16'h0);
    step("R2", 16'h0180, 16'h2000, 4'h0, 16'h0);
    step("R2", 16'h01FF, 16'h2000, 4'h0, 16'h0);
    step("R2", 16'h0100, 16'h2000, 4'h0, 16'h0);
    step("R2", 16'h0180, 16'h0010, 4'h0, 16'h0);
    step("R5", 16'h0380, 16'h4444, 4'h0, 16'h0);

    // R6 R7: loop counts
    step("R7", 16'o077205, 16'h3000, 4'hF, 16'd1);
    step("R7", 16'o077577, 16'h3000, 4'h0, 16'd0);
    step("R6", 16'o077777, 16'h0040, 4'h0, 16'd2);
    step("R6", 16'o077000, 16'h3000, 4'h0, 16'h8000);
    step("R7", 16'o077077, 16'h0020, 4'h0, 16'd9);

    // R8: encodings outside both groups
    step("R8", 16'h0000, 16'h5555, 4'hF, 16'h1);
    step("R8", 16'h00FF, 16'h5555, 4'hF, 16'h1);
    step("R8", 16'h0800, 16'h5555, 4'h0, 16'h1);
    step("R8", 16'h8800, 16'h5555, 4'h0, 16'h1);
    step("R8", 16'o076000, 16'h5555, 4'h0, 16'h7);
    step("R8", 16'hF000, 16'h5555, 4'h0, 16'h7);
    // R9: branch after a loop clears write-back
    step("R6", 16'o077301, 16'h6000, 4'h0, 16'd5);
    step("R9", 16'h8700, 16'h6000, 4'h1, 16'd5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule